// File: doc/BRIEF.md
# Manchester Serial Word Transmitter

This block turns one 16-bit word into a bi-phase serial stream for a half-duplex command/response bus running at 1 Mb/s. A processor-side interface hands it a word together with a choice of sync type. The block sends a sync header three bit times long, then the sixteen data bits, then a parity bit that it computes itself. Every data and parity bit is Manchester coded. The sync is not Manchester coded: it holds a level for one and a half bit times, then the opposite level for one and a half bit times, so a receiver can tell it apart from data.

The block drives a complementary output pair and an enable for the line driver. The enable is asserted only while a word is on the line. A single holding register lets software queue the next word while the parity bit of the current word is going out. A word queued in that window follows the current one with no idle time, which is how multi-word messages are built. All timing comes from a clock-enable strobe running at eight times the bit rate, so each half-bit lasts four strobes. The transmitter runs on its own and shares no state with any receiver.

Top module: `mw_serial_tx`

## Requirements
- R1: After reset, and whenever no word is being sent, `line_p`, `line_n`, `drv_en` and `busy` are all 0 and `next_rdy` is 1. A reset in the middle of a word returns the outputs to this state.
- R2: A word starts with six half-bits of sync. With `wr_sync_cmd`=1 (command/status sync) `line_p` is 1 for the first three half-bits and 0 for the next three. With `wr_sync_cmd`=0 (data sync) the levels are reversed.
- R3: After the sync, the data bits go out starting with bit 15. Each bit takes two half-bits: a 1 is sent as `line_p` high then low, and a 0 as low then high.
- R4: The two half-bits after bit 0 carry the parity bit, coded like a data bit. The parity bit makes the total number of ones across the sixteen data bits and the parity bit odd.
- R5: While a word is being sent, `drv_en` and `busy` are 1 and `line_n` is the complement of `line_p`. This holds from the first sync half-bit through the end of the second parity half-bit. One word takes 40 half-bits.
- R6: `next_rdy` is 1 when the block is idle, or during the two parity half-bits when no word is queued. It is 0 at all other times.
- R7: A pulse on `wr_en` while `next_rdy` is 0 has no effect. The word is neither queued nor sent.
- R8: A word written during the parity bit of the current word starts with its first sync half-bit immediately after the last parity half-bit. `drv_en` stays 1 across the join.
- R9: A word written while the block is idle starts on the first tick of `tick_8x` after the write is accepted. With registered outputs, `drv_en` rises one clock later.
- R10: Each half-bit lasts `TICKS_PER_HALF` (4) ticks of `tick_8x`. While `tick_8x` is 0, the transmitter state and the line levels do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_8x | input | 1 | Clock enable at eight times the bit rate |
| wr_en | input | 1 | One-clock write strobe for a new word |
| wr_word | input | 16 | Word to transmit |
| wr_sync_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| line_p | output | 1 | Serial line, true phase |
| line_n | output | 1 | Serial line, complement phase |
| drv_en | output | 1 | Line driver enable |
| busy | output | 1 | A word is being sent |
| next_rdy | output | 1 | A new word may be written |

## Verification
The hardest case to reach is the join between two words. A write must land inside the two-half-bit parity window, which is only eight ticks long. It must also be checked that no extra half-bit or gap appears at the boundary. The stimulus follows the serial stream one tick at a time and counts half-bits. When the count reaches the first parity half-bit, the stimulus issues the next write. It then keeps sampling straight into the second word without resynchronising. In the same run, an earlier write during the data bits shows that the queue stays empty outside the window.

// File: rtl/mwtx_pkg.sv
// Package: mwtx_pkg
// Shared types for the serial word transmitter: the sync flavour that is
// stored with each queued word, and the word phase that the encoder reports.
package mwtx_pkg;

    typedef enum logic {
        SYNC_DATA = 1'b0,
        SYNC_CMD  = 1'b1
    } sync_kind_e;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_DATA = 2'd1,
        PH_PAR  = 2'd2
    } phase_e;

endpackage

// File: rtl/mwtx_timing.sv
// Module: mwtx_timing
// Counts clock-enable ticks into half-bits and half-bits into words.
// Assumes: tick is a single-clock strobe. A queued word starts either on the
// first tick while idle or on the tick that closes the last half-bit of the
// current word, so back-to-back words leave no gap.
module mwtx_timing #(
    parameter int TICKS_PER_HALF = 4,
    parameter int HALF_COUNT     = 40,
    parameter int HALF_W         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              word_waiting,
    output logic              active,
    output logic [HALF_W-1:0] half_idx,
    output logic              load_word
);

    localparam int CNT_W = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;

    logic [CNT_W-1:0] tick_cnt;
    logic             half_end;
    logic             word_end;

    // Purpose: decode the closing tick of a half-bit and of a whole word.
    always_comb begin
        half_end  = tick && active && (tick_cnt == CNT_W'(TICKS_PER_HALF - 1));
        word_end  = half_end && (half_idx == HALF_W'(HALF_COUNT - 1));
        load_word = word_waiting && ((tick && !active) || word_end);
    end

    // Purpose: advance the tick and half-bit counters and the active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            tick_cnt <= '0;
            half_idx <= '0;
        end else if (load_word) begin
            active   <= 1'b1;
            tick_cnt <= '0;
            half_idx <= '0;
        end else if (word_end) begin
            active   <= 1'b0;
            tick_cnt <= '0;
            half_idx <= '0;
        end else if (half_end) begin
            tick_cnt <= '0;
            half_idx <= half_idx + HALF_W'(1);
        end else if (tick && active) begin
            tick_cnt <= tick_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/mwtx_stage.sv
// Module: mwtx_stage
// Holds one queued word and the word currently on the line.
// Assumes: accept_ok is low whenever a word is already queued, so a write and
// a transfer to the line register never meet in the same clock. Parity is
// computed once, when the word moves to the line register.
module mwtx_stage
    import mwtx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              wr_sync_cmd,
    input  logic              accept_ok,
    input  logic              load_word,
    output logic              word_waiting,
    output logic [DATA_W-1:0] cur_word,
    output sync_kind_e        cur_sync,
    output logic              cur_par
);

    logic [DATA_W-1:0] pend_word;
    sync_kind_e        pend_sync;

    // Purpose: take a write into the queue slot, or release it to the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_waiting <= 1'b0;
            pend_word    <= '0;
            pend_sync    <= SYNC_DATA;
        end else if (load_word) begin
            word_waiting <= 1'b0;
        end else if (wr_en && accept_ok) begin
            word_waiting <= 1'b1;
            pend_word    <= wr_word;
            pend_sync    <= sync_kind_e'(wr_sync_cmd);
        end
    end

    // Purpose: copy the queued word to the line register and add odd parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word <= '0;
            cur_sync <= SYNC_DATA;
            cur_par  <= 1'b1;
        end else if (load_word) begin
            cur_word <= pend_word;
            cur_sync <= pend_sync;
            cur_par  <= ~^pend_word;
        end
    end

endmodule

// File: rtl/mwtx_encoder.sv
// Module: mwtx_encoder
// Maps the half-bit index of the word to a line level: a non-Manchester
// sync over SYNC_HALVES half-bits, then the data bits MSB first, then parity.
// Assumes: SYNC_HALVES is even. Purely combinational.
module mwtx_encoder
    import mwtx_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_HALVES = 6,
    parameter int HALF_W      = 6
) (
    input  logic [HALF_W-1:0] half_idx,
    input  logic [DATA_W-1:0] cur_word,
    input  sync_kind_e        cur_sync,
    input  logic              cur_par,
    output phase_e            phase,
    output logic              level
);

    localparam int DATA_END = SYNC_HALVES + 2 * DATA_W;

    logic [HALF_W-1:0] rel;
    logic [HALF_W-1:0] bit_pos;
    logic [DATA_W-1:0] bit_mask;
    logic              data_bit;

    // Purpose: select the data bit addressed by the half-bit index.
    always_comb begin
        rel      = half_idx - HALF_W'(SYNC_HALVES);
        bit_pos  = rel >> 1;
        bit_mask = {1'b1, {(DATA_W-1){1'b0}}} >> bit_pos;
        data_bit = |(cur_word & bit_mask);
    end

    // Purpose: choose phase and level for the current half-bit.
    always_comb begin
        if (half_idx < HALF_W'(SYNC_HALVES)) begin
            phase = PH_SYNC;
            if (half_idx < HALF_W'(SYNC_HALVES / 2))
                level = (cur_sync == SYNC_CMD);
            else
                level = (cur_sync != SYNC_CMD);
        end else if (half_idx < HALF_W'(DATA_END)) begin
            phase = PH_DATA;
            level = rel[0] ? ~data_bit : data_bit;
        end else begin
            phase = PH_PAR;
            level = rel[0] ? ~cur_par : cur_par;
        end
    end

endmodule

// File: rtl/mw_serial_tx.sv
// Module: mw_serial_tx
// Serial word transmitter for a half-duplex bi-phase bus. It queues one
// word, sends sync, data and odd parity, and registers the line outputs so
// the pair and the driver enable switch together and without glitches.
// Assumes: tick_8x is a single-clock strobe at 8x the bit rate, and the clock
// runs at least twice as fast as the strobe.
module mw_serial_tx
    import mwtx_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int TICKS_PER_HALF = 4,
    parameter int SYNC_HALVES    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_8x,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              wr_sync_cmd,
    output logic              line_p,
    output logic              line_n,
    output logic              drv_en,
    output logic              busy,
    output logic              next_rdy
);

    localparam int HALF_COUNT = SYNC_HALVES + 2 * DATA_W + 2;
    localparam int HALF_W     = $clog2(HALF_COUNT);

    logic              active;
    logic [HALF_W-1:0] half_idx;
    logic              load_word;
    logic              word_waiting;
    logic [DATA_W-1:0] cur_word;
    sync_kind_e        cur_sync;
    logic              cur_par;
    phase_e            phase;
    logic              level;

    mwtx_timing #(
        .TICKS_PER_HALF(TICKS_PER_HALF),
        .HALF_COUNT    (HALF_COUNT),
        .HALF_W        (HALF_W)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_8x),
        .word_waiting(word_waiting),
        .active      (active),
        .half_idx    (half_idx),
        .load_word   (load_word)
    );

    mwtx_stage #(
        .DATA_W(DATA_W)
    ) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_word     (wr_word),
        .wr_sync_cmd (wr_sync_cmd),
        .accept_ok   (next_rdy),
        .load_word   (load_word),
        .word_waiting(word_waiting),
        .cur_word    (cur_word),
        .cur_sync    (cur_sync),
        .cur_par     (cur_par)
    );

    mwtx_encoder #(
        .DATA_W     (DATA_W),
        .SYNC_HALVES(SYNC_HALVES),
        .HALF_W     (HALF_W)
    ) u_encoder (
        .half_idx(half_idx),
        .cur_word(cur_word),
        .cur_sync(cur_sync),
        .cur_par (cur_par),
        .phase   (phase),
        .level   (level)
    );

    // Purpose: open the write window when idle or during parity with the queue empty.
    always_comb begin
        next_rdy = !word_waiting && (!active || (phase == PH_PAR));
    end

    // Purpose: register the line pair, driver enable and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_p <= 1'b0;
            line_n <= 1'b0;
            drv_en <= 1'b0;
            busy   <= 1'b0;
        end else begin
            line_p <= active && level;
            line_n <= active && !level;
            drv_en <= active;
            busy   <= active;
        end
    end

endmodule

// File: rtl/mwtx_checker.sv
// Module: mwtx_checker
// Clocked properties of the serial word transmitter, bound into the top.
module mwtx_checker
    import mwtx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HALF_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic              next_rdy,
    input logic              drv_en,
    input logic              busy,
    input logic              line_p,
    input logic              line_n,
    input logic              active,
    input logic [HALF_W-1:0] half_idx,
    input logic              load_word,
    input logic              word_waiting,
    input logic [DATA_W-1:0] cur_word,
    input logic              cur_par,
    input phase_e            phase
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> (!line_p && !line_n));

    p_pair_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (line_p != line_n));

    p_enable_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> (drv_en && busy));

    p_parity_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_word |=> (^{cur_word, cur_par}));

    p_ready_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (next_rdy && active) |-> (phase == PH_PAR));

    p_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !next_rdy && !word_waiting) |=> !word_waiting);

    p_word_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_word |=> (active && (half_idx == '0)));

    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(active) && $stable(half_idx)));

endmodule

bind mw_serial_tx mwtx_checker #(
    .DATA_W(DATA_W),
    .HALF_W(HALF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_8x),
    .wr_en       (wr_en),
    .next_rdy    (next_rdy),
    .drv_en      (drv_en),
    .busy        (busy),
    .line_p      (line_p),
    .line_n      (line_n),
    .active      (active),
    .half_idx    (half_idx),
    .load_word   (load_word),
    .word_waiting(word_waiting),
    .cur_word    (cur_word),
    .cur_par     (cur_par),
    .phase       (phase)
);

// File: tb/sim_mw_serial_tx.sv
// Bench for mw_serial_tx: a table of words walked by one loop, then directed
// tests for chaining, ignored writes, tick stalls and reset mid-word.
module sim_mw_serial_tx;

    localparam int DIV   = 3;
    localparam int HALFS = 40;
    localparam int TPH   = 4;
    localparam int NVEC  = 6;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 16'h0000}, {1'b0, 16'hFFFF}, {1'b1, 16'hA5C3},
        {1'b0, 16'h8001}, {1'b1, 16'h7FFE}, {1'b0, 16'h1234}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_8x = 1'b0;
    logic        tick_run = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        wr_sync_cmd = 1'b0;
    logic        line_p, line_n, drv_en, busy, next_rdy;
    logic [1:0]  div_cnt = '0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div_cnt <= (div_cnt == 2'(DIV - 1)) ? 2'd0 : div_cnt + 2'd1;
        tick_8x <= tick_run && (div_cnt == 2'(DIV - 1));
    end

    mw_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick_8x(tick_8x), .wr_en(wr_en),
        .wr_word(wr_word), .wr_sync_cmd(wr_sync_cmd), .line_p(line_p),
        .line_n(line_n), .drv_en(drv_en), .busy(busy), .next_rdy(next_rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_level(input logic cmd, input logic [15:0] w, input int h);
        int ones;
        logic b, p;
        if (h < 6) return (h < 3) ? cmd : !cmd;
        if (h < 38) begin
            b = w[15 - (h - 6) / 2];
            return ((h - 6) % 2 == 0) ? b : !b;
        end
        ones = 0;
        for (int i = 0; i < 16; i++) ones += int'(w[i]);
        p = (ones % 2 == 0);
        return (h == 38) ? p : !p;
    endfunction

    task automatic tick_sample();
        @(negedge clk);
        while (!tick_8x) @(negedge clk);
    endtask

    task automatic pulse_write(input logic [16:0] v);
        wr_sync_cmd = v[16];
        wr_word     = v[15:0];
        wr_en       = 1'b1;
        @(negedge clk);
        wr_en       = 1'b0;
    endtask

    // Write while idle and check that the word starts promptly (R9).
    task automatic start_word(input logic [16:0] v);
        int n;
        @(negedge clk);
        pulse_write(v);
        n = 0;
        while (!drv_en && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n >= 2 && n <= DIV + 2, "R9 start delay", n, DIV);
    endtask

    // Follow one word tick by tick; optional junk write and chained write.
    task automatic capture_word(input logic [16:0] v, input int junk_at,
                                input int next_at, input logic [16:0] nxt);
        logic e;
        int   h;
        string tag;
        for (int i = 0; i < HALFS * TPH; i++) begin
            tick_sample();
            h   = i / TPH;
            e   = exp_level(v[16], v[15:0], h);
            tag = (h < 6) ? "R2 sync" : (h < 38) ? "R3 data" : "R4 parity";
            chk(drv_en && busy && line_p == e && line_n == !e, tag,
                {drv_en, busy, line_p, line_n}, {2'b11, e, !e});
            if (i == 148) chk(next_rdy == 1'b0, "R6 closed before parity", next_rdy, 0);
            if (i == 152) chk(next_rdy == 1'b1, "R6 open in parity", next_rdy, 1);
            if (i == junk_at) pulse_write(17'h1_0F0F);
            if (i == next_at) pulse_write(nxt);
        end
    endtask

    task automatic expect_idle(input string req);
        tick_sample();
        chk(!drv_en && !busy && !line_p && !line_n && next_rdy, req,
            {drv_en, busy, line_p, line_n, next_rdy}, 5'b00001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!line_p && !line_n, "R1 lines after reset", {line_p, line_n}, 0);
        chk(!drv_en && !busy, "R1 enable after reset", {drv_en, busy}, 0);
        chk(next_rdy, "R1 ready after reset", next_rdy, 1);

        // Table walk: each word sent alone, then the line returns to idle.
        for (int k = 0; k < NVEC; k++) begin
            start_word(VEC[k]);
            capture_word(VEC[k], -1, -1, '0);
            expect_idle("R5 release after word");
        end

        // R7 junk write during data, R8 chained word written in parity.
        start_word(17'h0_C35A);
        capture_word(17'h0_C35A, 40, 152, 17'h1_5A5A);
        capture_word(17'h1_5A5A, -1, -1, '0);
        expect_idle("R7 junk word not sent");

        // R10: stall the tick, lines must hold.
        start_word(17'h1_00FF);
        repeat (10) tick_sample();
        @(negedge clk);
        tick_run = 1'b0;
        repeat (2) @(negedge clk);
        snap = {line_p, line_n};
        repeat (30) @(negedge clk);
        chk({line_p, line_n} == snap && drv_en, "R10 hold without tick",
            {drv_en, line_p, line_n}, {1'b1, snap});
        tick_run = 1'b1;
        while (drv_en) @(negedge clk);
        expect_idle("R10 word completes after stall");

        // R1: reset in the middle of a word.
        start_word(17'h0_FFFF);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!drv_en && !line_p && !line_n && !busy, "R1 reset mid-word",
            {drv_en, busy, line_p, line_n}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1 idle after reset release");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule